// File: doc/BRIEF.md
# Bus Error Status and Interrupt Logger

This block sits beside a bridge between a PCI-style bus and an internal bus. It takes error events from that bridge and turns them into recorded state. Each event carries a kind: an uncorrectable address/attribute error, a correctable address/attribute error, an uncorrectable data error on an outbound read, or one on an outbound write. Each event also carries the bus mode in force: conventional, PCI-X, or PCI-X mode 2. For every event the block does four things. It sets sticky bits in a bus status word and an interrupt status word. It chooses how the bridge should respond on the bus. It may raise a one-cycle request to drive the system-error pin. In mode 2 it may pulse a strobe that tells the ECC logging logic to capture.

Software clears status bits by write-1-to-clear strobes. Per-source mask bits, plus a separate enable for the externally detected system-error bit, decide which interrupt status bits reach the single registered interrupt output.

The encodings are as follows. `ev_kind` is 0 for an uncorrectable address/attribute error, 1 for a correctable address/attribute error, 2 for an outbound read data error and 3 for an outbound write data error. `ev_mode` is 0 for conventional, 1 for PCI-X and 2 for PCI-X mode 2; the value 3 behaves like PCI-X. `resp` is 0 for complete normally, 1 for ignore (master-abort) and 2 for signal the parity-error pin. The event outputs `resp`, `resp_valid`, `serr_req` and `ecc_log_upd`, and both status words, change on the clock edge that samples the event. `irq_out` follows one edge later.

Top module: `bus_err_logger`

## Requirements
- R1: After reset, both status words, `irq_out`, `serr_req`, `ecc_log_upd`, `resp_valid` and `resp` are all 0.
- R2: An uncorrectable address/attribute error (kind 0) in conventional mode gives `resp`=1 (ignore) with `resp_valid`=1, and requests the system-error pin.
- R3: Kind 0 in PCI-X mode or in mode 2 gives `resp`=0 (complete) and requests the system-error pin.
- R4: `serr_req`, bus status bit 14 and interrupt status bit 10 are set only when an event needs the system-error pin and `cmd_serr_en` is 1. With `cmd_serr_en`=0 none of the three is set.
- R5: Kind 0 and kind 2 set the detected-parity bits: bus status bit 15 and interrupt status bit 9.
- R6: An address/attribute error of either kind in mode 2 pulses `ecc_log_upd`. Kind 1 in mode 2 sets interrupt status bit 14 and gives `resp`=0. Kind 1 in the other modes sets no status bit.
- R7: Kind 2 sets master parity error (bus status bit 8, interrupt status bit 0) and gives `resp`=2. It requests the system-error pin only when the mode is not conventional.
- R8: Kind 3 sets master parity error and gives `resp`=0. It requests the system-error pin only when the mode is not conventional or `ev_msi` is 1.
- R9: A high `ext_serr` sets interrupt status bit 4. That bit reaches the interrupt only while `det_irq_en` is 1.
- R10: Writing 1 to a bit of `bsr_clr` or `isr_clr` clears that status bit. If a clear and a new set hit the same bit in the same cycle, the bit ends up set.
- R11: `irq_out` is registered: one cycle after the status changes, it equals the OR of the enabled interrupt status bits. Bit 0 is gated by mask bit 2, bit 9 by mask bit 7, bit 10 by mask bit 6 and bit 14 by mask bit 11, where a mask bit of 1 blocks its source. Bit 4 is gated by `det_irq_en`.
- R12: `serr_req` is a single-cycle pulse for each event that requests the pin, and it stays 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Error event present this cycle |
| ev_kind | input | 2 | Event kind (0..3, see above) |
| ev_mode | input | 2 | Bus mode of the event |
| ev_msi | input | 1 | Outbound write carries a message-signalled interrupt |
| ext_serr | input | 1 | System-error detected on the bus |
| cmd_serr_en | input | 1 | Command-register system-error enable |
| det_irq_en | input | 1 | Lets interrupt status bit 4 onto the interrupt |
| irq_mask | input | 12 | Interrupt mask register (1 blocks) |
| bsr_clr | input | 16 | Write-1-to-clear strobes for the bus status word |
| isr_clr | input | 16 | Write-1-to-clear strobes for the interrupt status word |
| bus_status | output | 16 | Sticky bus status word |
| irq_status | output | 16 | Sticky interrupt status word |
| irq_out | output | 1 | Combined registered interrupt |
| serr_req | output | 1 | One-cycle request to drive the system-error pin |
| ecc_log_upd | output | 1 | One-cycle ECC log capture strobe |
| resp_valid | output | 1 | `resp` holds the response for the last event |
| resp | output | 2 | Bus response choice |

## Verification
Some properties are checked by assertions on every cycle. Status bits never drop without a matching clear strobe, and no bit appears in a cycle with no event. `serr_req` never rises while the command enable was off. `ecc_log_upd` and `resp_valid` each trace back to an event in the right mode, and `irq_out` never rises without a pending status bit. The full mapping from each kind and mode to its status bits and response can only be shown by the directed scenarios. The same holds for the message-signalled write exception, the mask positions and the set-wins-over-clear collision.

// File: rtl/bus_err_logger.sv
module bus_err_logger (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [1:0]  ev_kind,
  input  logic [1:0]  ev_mode,
  input  logic        ev_msi,
  input  logic        ext_serr,
  input  logic        cmd_serr_en,
  input  logic        det_irq_en,
  input  logic [11:0] irq_mask,
  input  logic [15:0] bsr_clr,
  input  logic [15:0] isr_clr,
  output logic [15:0] bus_status,
  output logic [15:0] irq_status,
  output logic        irq_out,
  output logic        serr_req,
  output logic        ecc_log_upd,
  output logic        resp_valid,
  output logic [1:0]  resp
);
  localparam logic [1:0] K_UA = 2'd0, K_CA = 2'd1, K_RD = 2'd2, K_WR = 2'd3;
  localparam logic [1:0] M_CONV = 2'd0, M_X2 = 2'd2;
  localparam logic [1:0] R_COMPLETE = 2'd0, R_IGNORE = 2'd1, R_PERR = 2'd2;

  logic is_ua, is_ca, is_rd, is_wr, pcix, need_serr, serr_go, det_par, mpe, ce;
  logic [15:0] bsr_set, isr_set, irq_en;
  logic [1:0]  resp_nxt;

  assign is_ua = ev_valid && ev_kind == K_UA;
  assign is_ca = ev_valid && ev_kind == K_CA;
  assign is_rd = ev_valid && ev_kind == K_RD;
  assign is_wr = ev_valid && ev_kind == K_WR;
  assign pcix  = ev_mode != M_CONV;

  assign need_serr = is_ua | (is_rd & pcix) | (is_wr & (pcix | ev_msi));
  assign serr_go   = need_serr & cmd_serr_en;
  assign det_par   = is_ua | is_rd;
  assign mpe       = is_rd | is_wr;
  assign ce        = is_ca & (ev_mode == M_X2);

  always_comb begin
    bsr_set     = '0;
    bsr_set[8]  = mpe;
    bsr_set[14] = serr_go;
    bsr_set[15] = det_par;
    isr_set     = '0;
    isr_set[0]  = mpe;
    isr_set[4]  = ext_serr;
    isr_set[9]  = det_par;
    isr_set[10] = serr_go;
    isr_set[14] = ce;
  end

  always_comb begin
    irq_en     = '0;
    irq_en[0]  = ~irq_mask[2];
    irq_en[4]  = det_irq_en;
    irq_en[9]  = ~irq_mask[7];
    irq_en[10] = ~irq_mask[6];
    irq_en[14] = ~irq_mask[11];
  end

  always_comb begin
    if (is_ua && !pcix) resp_nxt = R_IGNORE;
    else if (is_rd)     resp_nxt = R_PERR;
    else                resp_nxt = R_COMPLETE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_status  <= '0;
      irq_status  <= '0;
      irq_out     <= 1'b0;
      serr_req    <= 1'b0;
      ecc_log_upd <= 1'b0;
      resp_valid  <= 1'b0;
      resp        <= R_COMPLETE;
    end else begin
      bus_status  <= (bus_status & ~bsr_clr) | bsr_set;
      irq_status  <= (irq_status & ~isr_clr) | isr_set;
      irq_out     <= |(irq_status & irq_en);
      serr_req    <= serr_go;
      ecc_log_upd <= (is_ua | is_ca) && ev_mode == M_X2;
      resp_valid  <= ev_valid;
      resp        <= ev_valid ? resp_nxt : R_COMPLETE;
    end
  end
endmodule

// File: rtl/bus_err_logger_chk.sv
module bus_err_logger_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_valid,
  input logic [1:0]  ev_kind,
  input logic [1:0]  ev_mode,
  input logic        ext_serr,
  input logic        cmd_serr_en,
  input logic [15:0] bsr_clr,
  input logic [15:0] isr_clr,
  input logic [15:0] bus_status,
  input logic [15:0] irq_status,
  input logic        irq_out,
  input logic        serr_req,
  input logic        ecc_log_upd,
  input logic        resp_valid
);
  p_sticky_bsr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bus_status & $past(bus_status & ~bsr_clr)) == $past(bus_status & ~bsr_clr)));

  p_sticky_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_status & $past(irq_status & ~isr_clr)) == $past(irq_status & ~isr_clr)));

  p_quiet_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !ext_serr) |=> ((irq_status & ~$past(irq_status)) == 16'h0));

  p_serr_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_serr_en) |=> !serr_req);

  p_serr_needs_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid) |=> !serr_req);

  p_ecc_mode2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_mode != 2'd2) |=> !ecc_log_upd);

  p_ecc_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind[1]) |=> !ecc_log_upd);

  p_resp_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid) |=> !resp_valid);

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_status) == 16'h0) |-> !irq_out);
endmodule

bind bus_err_logger bus_err_logger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
  .ev_mode(ev_mode), .ext_serr(ext_serr), .cmd_serr_en(cmd_serr_en),
  .bsr_clr(bsr_clr), .isr_clr(isr_clr), .bus_status(bus_status),
  .irq_status(irq_status), .irq_out(irq_out), .serr_req(serr_req),
  .ecc_log_upd(ecc_log_upd), .resp_valid(resp_valid)
);

// File: tb/test_bus_err_logger.sv
module test_bus_err_logger;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 0, ev_msi = 0, ext_serr = 0, cmd_serr_en = 0, det_irq_en = 0;
  logic [1:0] ev_kind = 0, ev_mode = 0;
  logic [11:0] irq_mask = 0;
  logic [15:0] bsr_clr = 0, isr_clr = 0;
  logic [15:0] bus_status, irq_status;
  logic irq_out, serr_req, ecc_log_upd, resp_valid;
  logic [1:0] resp;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_err_logger i_bus_err_logger (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_mode(ev_mode), .ev_msi(ev_msi), .ext_serr(ext_serr),
    .cmd_serr_en(cmd_serr_en), .det_irq_en(det_irq_en), .irq_mask(irq_mask),
    .bsr_clr(bsr_clr), .isr_clr(isr_clr), .bus_status(bus_status),
    .irq_status(irq_status), .irq_out(irq_out), .serr_req(serr_req),
    .ecc_log_upd(ecc_log_upd), .resp_valid(resp_valid), .resp(resp));

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); bsr_clr = '1; isr_clr = '1;
    @(negedge clk); bsr_clr = '0; isr_clr = '0;
    @(negedge clk);
  endtask

  // drive one event for one cycle; returns at the negedge after the sampling edge
  task automatic send(logic [1:0] k, logic [1:0] m, logic msi);
    @(negedge clk); ev_valid = 1; ev_kind = k; ev_mode = m; ev_msi = msi;
    @(negedge clk); ev_valid = 0; ev_msi = 0;
  endtask

  task automatic t_reset();
    chk("R1", "bus_status", bus_status, 0);
    chk("R1", "irq_status", irq_status, 0);
    chk("R1", "irq_out", irq_out, 0);
    chk("R1", "serr_req", serr_req, 0);
    chk("R12", "serr_req in reset", serr_req, 0);
    chk("R1", "ecc/resp", {ecc_log_upd, resp_valid, resp}, 0);
  endtask

  task automatic t_ua_conv();
    cmd_serr_en = 1; irq_mask = 0;
    send(2'd0, 2'd0, 0);
    chk("R2", "resp", resp, 1);
    chk("R2", "resp_valid", resp_valid, 1);
    chk("R2", "serr_req", serr_req, 1);
    chk("R5", "bus_status", bus_status, 16'hC000);
    chk("R5", "irq_status", irq_status, 16'h0600);
    chk("R6", "ecc conv", ecc_log_upd, 0);
    @(negedge clk);
    chk("R12", "serr single pulse", serr_req, 0);
    chk("R11", "irq_out", irq_out, 1);
    clear_all();
  endtask

  task automatic t_ua_pcix();
    send(2'd0, 2'd1, 0);
    chk("R3", "resp x1", resp, 0);
    chk("R3", "serr x1", serr_req, 1);
    chk("R3", "bsr x1", bus_status, 16'hC000);
    chk("R6", "ecc x1", ecc_log_upd, 0);
    send(2'd0, 2'd2, 0);
    chk("R3", "resp x2", resp, 0);
    chk("R6", "ecc x2", ecc_log_upd, 1);
    clear_all();
  endtask

  task automatic t_serr_off();
    cmd_serr_en = 0;
    send(2'd0, 2'd1, 0);
    chk("R4", "serr off", serr_req, 0);
    chk("R4", "bsr off", bus_status, 16'h8000);
    chk("R4", "isr off", irq_status, 16'h0200);
    send(2'd2, 2'd1, 0);
    chk("R4", "serr off rd", serr_req, 0);
    cmd_serr_en = 1;
    clear_all();
  endtask

  task automatic t_corr();
    send(2'd1, 2'd2, 0);
    chk("R6", "isr ce", irq_status, 16'h4000);
    chk("R6", "ecc ce", ecc_log_upd, 1);
    chk("R6", "resp ce", resp, 0);
    chk("R6", "serr ce", serr_req, 0);
    clear_all();
    send(2'd1, 2'd1, 0);
    chk("R6", "isr ce x1", irq_status, 0);
    chk("R6", "bsr ce x1", bus_status, 0);
    chk("R6", "ecc ce x1", ecc_log_upd, 0);
    clear_all();
  endtask

  task automatic t_rd();
    send(2'd2, 2'd0, 0);
    chk("R7", "bsr rd", bus_status, 16'h8100);
    chk("R7", "isr rd", irq_status, 16'h0201);
    chk("R7", "resp rd", resp, 2);
    chk("R7", "serr rd conv", serr_req, 0);
    clear_all();
    send(2'd2, 2'd1, 0);
    chk("R7", "serr rd x1", serr_req, 1);
    chk("R7", "bsr rd x1", bus_status, 16'hC100);
    clear_all();
  endtask

  task automatic t_wr();
    send(2'd3, 2'd0, 0);
    chk("R8", "bsr wr", bus_status, 16'h0100);
    chk("R8", "isr wr", irq_status, 16'h0001);
    chk("R8", "resp wr", resp, 0);
    chk("R8", "serr wr conv", serr_req, 0);
    send(2'd3, 2'd0, 1);
    chk("R8", "serr wr msi", serr_req, 1);
    send(2'd3, 2'd2, 0);
    chk("R8", "serr wr x2", serr_req, 1);
    clear_all();
  endtask

  task automatic t_ext();
    det_irq_en = 0;
    @(negedge clk); ext_serr = 1;
    @(negedge clk); ext_serr = 0;
    chk("R9", "isr ext", irq_status, 16'h0010);
    @(negedge clk);
    chk("R9", "irq ext disabled", irq_out, 0);
    det_irq_en = 1;
    @(negedge clk);
    chk("R9", "irq ext enabled", irq_out, 1);
    det_irq_en = 0;
    clear_all();
  endtask

  task automatic t_mask();
    irq_mask = 12'h800;
    send(2'd1, 2'd2, 0);
    @(negedge clk);
    chk("R11", "irq bit14 masked", irq_out, 0);
    irq_mask = 12'h000;
    @(negedge clk);
    chk("R11", "irq bit14 open", irq_out, 1);
    clear_all();
    irq_mask = 12'h004;
    send(2'd3, 2'd0, 0);
    @(negedge clk);
    chk("R11", "irq bit0 masked", irq_out, 0);
    irq_mask = 12'h000;
    clear_all();
  endtask

  task automatic t_w1c();
    send(2'd2, 2'd1, 0);
    @(negedge clk); isr_clr = 16'h0001; bsr_clr = 16'h4000;
    @(negedge clk); isr_clr = 0; bsr_clr = 0;
    chk("R10", "isr after w1c", irq_status, 16'h0600);
    chk("R10", "bsr after w1c", bus_status, 16'h8100);
    @(negedge clk); ev_valid = 1; ev_kind = 2'd3; ev_mode = 2'd0; bsr_clr = 16'h0100; isr_clr = 16'h0001;
    @(negedge clk); ev_valid = 0; bsr_clr = 0; isr_clr = 0;
    chk("R10", "set wins bsr", bus_status, 16'h8100);
    chk("R10", "set wins isr", irq_status, 16'h0601);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_ua_conv();
    t_ua_pcix();
    t_serr_off();
    t_corr();
    t_rd();
    t_wr();
    t_ext();
    t_mask();
    t_w1c();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule